// File: doc/BRIEF.md
# Wait-State Read Responder

This block is the memory side of an interlocked read handshake. A bus master presents an address, raises an address strobe, drives the read/write line to its read level and raises a data strobe. After both strobes pass through two-flop synchronizers, the responder decodes the address into a 256-word internal store and registers the selected word. It then counts a programmable number of wait states and raises data acknowledge together with the output enable of the data bus.

Acknowledge and data are held for as long as the master keeps its data strobe high. After the master drops the strobe, the responder negates acknowledge, which closes the cycle. It accepts a new cycle only once both strobes have been seen low. The data bus reads zero whenever acknowledge is low, so a stored value of 0x00 can only be recognised as data by the acknowledge.

A dedicated preload port fills the store for test. It takes effect only while the responder is idle.

Top module: `memwait_responder`

## Requirements
- R1: After reset, data_ack and data_oe are 0 and data_out is 0.
- R2: A cycle starts only when addr_strobe, data_strobe and rd_wr = 1 (the read level) are all high. With any of the three missing, data_ack stays 0.
- R3: While data_ack is high, data_out equals the word stored at the address presented when the cycle started. This includes a stored word of 0x00.
- R4: With wait_cnt = N (0 to 15), data_ack rises exactly N + 4 clocks after the strobes are raised. The four fixed clocks are two synchronizer stages, one qualify clock and one acknowledge clock.
- R5: While data_strobe stays high, data_ack stays high and data_out does not change.
- R6: After data_strobe falls, data_ack stays high for two more clocks and is low from the third clock on.
- R7: data_oe always equals data_ack. data_out is 0 whenever data_oe is 0.
- R8: A preload write (pre_we = 1) updates the store only while no bus cycle is in progress. A preload write issued during a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strobe | input | 1 | Address valid strobe from the master, asynchronous |
| data_strobe | input | 1 | Master ready-to-read strobe, asynchronous |
| rd_wr | input | 1 | 1 = read, sampled when the strobes qualify |
| addr | input | 8 | Word address, held stable by the master during the cycle |
| wait_cnt | input | 4 | Number of wait states for the next cycle |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload address |
| pre_data | input | 8 | Preload data |
| data_out | output | 8 | Read data, zero when not enabled |
| data_oe | output | 1 | Data bus output enable |
| data_ack | output | 1 | Data acknowledge |

## Verification
On every cycle, the assertions check four things:
- data_oe matches data_ack, and the bus is zero while it is not enabled.
- data_out stays unchanged for as long as acknowledge is held.
- acknowledge cannot survive three sampled clocks of a low data strobe.

Some behaviours only the bench's scenarios can show:
- The exact N + 4 latency for each wait count.
- That the returned word is the right one, including a zero word.
- That partial or write-level strobes get no response.
- That a preload write made during an active cycle is lost.

// File: rtl/mwr_pkg.sv
// Package: shared types for the wait-state read responder.
package mwr_pkg;
    // Handshake controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for qualified strobes
        ST_FETCH = 2'd1,  // word registered, counting wait states
        ST_ACK   = 2'd2,  // acknowledge driven
        ST_DONE  = 2'd3   // acknowledge released, waiting for both strobes low
    } mwr_state_t;
endpackage

// File: rtl/mwr_sync.sv
// Module: mwr_sync
// Multi-stage flop synchronizer for a vector of independent single-bit
// asynchronous inputs. Assumes each bit is a level that is held for several
// clocks. No relationship between bits is preserved.
module mwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the sampled value one stage down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= async_in;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mwr_store.sv
// Module: mwr_store
// Word store with one write port and one registered read port. The read
// captures the word at raddr when rd_en is high. A write and a read of the
// same word in the same clock return the old word. There is no reset of
// the contents.
module mwr_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: apply preload writes
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: register the addressed word when a cycle is qualified
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mwr_ctrl.sv
// Module: mwr_ctrl
// Handshake controller. It qualifies synchronized strobes with the read
// level, counts wait states, drives acknowledge until the data strobe drops,
// and then waits until both strobes are low before rearming. Assumes rd_wr
// and wait_cnt are stable while the strobes are high.
module mwr_ctrl
    import mwr_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_s,
    input  logic            ds_s,
    input  logic            rd_wr,
    input  logic [WS_W-1:0] wait_cnt,
    output logic            fetch_en,
    output logic            ack,
    output logic            idle
);
    mwr_state_t      state_q, state_d;
    logic [WS_W-1:0] cnt_q, cnt_d;
    logic            qualify;

    assign qualify  = as_s && ds_s && rd_wr;
    assign fetch_en = (state_q == ST_IDLE) && qualify;
    assign ack      = (state_q == ST_ACK);
    assign idle     = (state_q == ST_IDLE);

    // Purpose: next-state and wait counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (qualify) begin
                    state_d = ST_FETCH;
                    cnt_d   = wait_cnt;
                end
            end
            ST_FETCH: begin
                if (cnt_q == '0) state_d = ST_ACK;
                else cnt_d = cnt_q - 1'b1;
            end
            ST_ACK: begin
                if (!ds_s) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!as_s && !ds_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/memwait_responder.sv
// Module: memwait_responder
// Memory-side read responder with programmable wait states and an
// interlocked acknowledge. Strobes are synchronized before use. Address,
// rd_wr and wait_cnt are assumed stable while the strobes are high. The
// data bus reads zero unless acknowledge is high.
module memwait_responder #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int WS_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic              data_strobe,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WS_W-1:0]   wait_cnt,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              data_ack
);
    logic [1:0]        strobes_s;
    logic              fetch_en, ack, idle;
    logic [DATA_W-1:0] word_q;

    mwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({addr_strobe, data_strobe}),
        .sync_out (strobes_s)
    );

    mwr_ctrl #(.WS_W(WS_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_s     (strobes_s[1]),
        .ds_s     (strobes_s[0]),
        .rd_wr    (rd_wr),
        .wait_cnt (wait_cnt),
        .fetch_en (fetch_en),
        .ack      (ack),
        .idle     (idle)
    );

    mwr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (pre_we && idle),
        .waddr (pre_addr),
        .wdata (pre_data),
        .rd_en (fetch_en),
        .raddr (addr),
        .rdata (word_q)
    );

    // Purpose: gate the data bus with acknowledge so zero never looks valid
    always_comb begin
        data_ack = ack;
        data_oe  = ack;
        data_out = ack ? word_q : '0;
    end
endmodule

// File: rtl/memwait_responder_chk.sv
// Module: memwait_responder_chk
// Checker bound to memwait_responder. It watches only the block's ports.
module memwait_responder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_strobe,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              data_ack
);
    // R7: the output enable follows acknowledge
    assert_oe_matches_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe == data_ack);

    // R7: the bus is zero while it is not enabled
    assert_bus_zero_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    // R5: data does not change while acknowledge is held
    assert_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ack && $past(data_ack)) |-> $stable(data_out));

    // R6: three sampled clocks of a low data strobe release acknowledge
    assert_ack_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_strobe && !$past(data_strobe) && !$past(data_strobe, 2)) |=> !data_ack);
endmodule

bind memwait_responder memwait_responder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_strobe (data_strobe),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .data_ack    (data_ack)
);

// File: tb/sim_memwait_responder.sv
// Scoreboard bench. The driver task pushes the expected word and latency
// into queues, and the monitor pops and compares them on each acknowledge rise.
module sim_memwait_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strobe = 1'b0, data_strobe = 1'b0, rd_wr = 1'b0;
    logic [7:0] addr = '0;
    logic [3:0] wait_cnt = '0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    logic [7:0] data_out;
    logic       data_oe, data_ack;

    int n_cmp = 0, n_bad = 0;
    int lat = 0;
    logic       ack_prev = 1'b0;
    logic [7:0] model [256];
    logic [7:0] exp_data_q [$];
    int         exp_lat_q  [$];

    always #5 clk = ~clk;

    memwait_responder u0 (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
        .rd_wr(rd_wr), .addr(addr), .wait_cnt(wait_cnt), .pre_we(pre_we),
        .pre_addr(pre_addr), .pre_data(pre_data), .data_out(data_out),
        .data_oe(data_oe), .data_ack(data_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Latency counter advanced on rising edges, cleared by the driver on falling edges
    always @(posedge clk) lat <= lat + 1;

    // Monitor: on each acknowledge rise, pop the expectation and compare (R3, R4)
    always @(negedge clk) begin
        if (rst_n && data_ack && !ack_prev) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R2 unexpected ack", 1, 0);
            end else begin
                automatic logic [7:0] ed = exp_data_q.pop_front();
                automatic int el = exp_lat_q.pop_front();
                check(data_out == ed, "R3 read data", data_out, ed);
                check(lat == el, "R4 ack latency", lat, el);
                check(data_oe == 1'b1, "R7 oe with ack", data_oe, 1);
            end
        end
        ack_prev <= data_ack;
    end

    task automatic preload(input logic [7:0] a, input logic [7:0] d, input bit takes);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        if (takes) model[a] = d;
    endtask

    // Driver: full read cycle with the handshake checks
    task automatic bus_read(input logic [7:0] a, input int ws, input int hold);
        logic [7:0] held;
        @(negedge clk);
        addr = a; wait_cnt = 4'(ws); rd_wr = 1'b1;
        addr_strobe = 1'b1; data_strobe = 1'b1; lat = 0;
        exp_data_q.push_back(model[a]);
        exp_lat_q.push_back(ws + 4);
        for (int i = 0; i < 40 && !data_ack; i++) @(negedge clk);
        held = data_out;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(data_ack == 1'b1, "R5 ack held", data_ack, 1);
            check(data_out == held, "R5 data held", data_out, held);
        end
        data_strobe = 1'b0; addr_strobe = 1'b0;
        @(negedge clk);
        check(data_ack == 1'b1, "R6 ack after drop +1", data_ack, 1);
        @(negedge clk);
        check(data_ack == 1'b1, "R6 ack after drop +2", data_ack, 1);
        @(negedge clk);
        check(data_ack == 1'b0, "R6 ack released +3", data_ack, 0);
        check(data_out == 8'd0 && data_oe == 1'b0, "R7 bus idle zero", data_out, 0);
        repeat (3) @(negedge clk);
    endtask

    // Partial strobes must not start a cycle (R2)
    task automatic no_cycle(input bit as_v, input bit ds_v, input bit rw_v);
        bit seen = 1'b0;
        @(negedge clk);
        addr = 8'h11; wait_cnt = 4'd0; rd_wr = rw_v;
        addr_strobe = as_v; data_strobe = ds_v;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (data_ack) seen = 1'b1;
        end
        check(!seen, "R2 no ack on partial strobes", seen, 0);
        addr_strobe = 1'b0; data_strobe = 1'b0; rd_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(data_ack == 1'b0 && data_oe == 1'b0, "R1 reset ack/oe", data_ack, 0);
        check(data_out == 8'd0, "R1 reset data", data_out, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) preload(8'(i), 8'(i * 7 + 3), 1'b1);
        preload(8'h40, 8'h00, 1'b1);
        bus_read(8'h05, 0, 0);
        bus_read(8'hFF, 15, 2);
        bus_read(8'h40, 3, 1);
        bus_read(8'h80, 1, 4);
        bus_read(8'h00, 7, 0);
        no_cycle(1'b1, 1'b0, 1'b1);
        no_cycle(1'b0, 1'b1, 1'b1);
        no_cycle(1'b1, 1'b1, 1'b0);
        preload(8'h33, 8'hA5, 1'b1);
        bus_read(8'h33, 2, 0);
        // R8: a preload issued during a cycle is ignored
        fork
            bus_read(8'h10, 6, 0);
            begin
                repeat (5) @(negedge clk);
                preload(8'h20, 8'h5A, 1'b0);
            end
        join
        bus_read(8'h20, 0, 0);
        check(exp_data_q.size() == 0, "R4 all expectations consumed", exp_data_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule